// File: doc/BRIEF.md
# Trigger Pulse Conditioner

This block sits on the device side of an isolated sync trigger path and turns a raw, possibly noisy trigger line into an output event that a receiver cannot misread. Each high run of the raw input is resynchronised and measured. It is judged only when it ends: a run that is too short is a glitch, and a run that never ends is a stuck or open line. A run of acceptable length becomes one output pulse of a fixed width. Two limits sit between a qualified run and the output: a minimum idle gap after the previous pulse, and a ceiling on the number of pulses in each rate window.

Permission is a separate level input. No pulse leaves the block while permission is low. Withdrawing permission cuts off a pulse that is already running. The block reports one registered reason code for the current inhibit condition and a fault flag for a stuck input. A saturating counter records every raw event that did not become a pulse. All widths, gaps and windows are counted in clock cycles.

Top module: `trig_pulse_conditioner`

## Requirements
- R1: The raw input passes through SYNC_STAGES (default 2) flops. A synchronised high run shorter than MIN_WIDTH cycles produces no output pulse.
- R2: A synchronised high run of MIN_WIDTH to STUCK_TIMEOUT-1 cycles produces exactly one output pulse. Its first high cycle follows the third rising clock edge after the first edge that samples the raw input low.
- R3: An output pulse that is not cut short is high for exactly OUT_WIDTH cycles.
- R4: After any output pulse ends, trigOut stays low for at least MIN_GAP cycles. A run that qualifies while a pulse is active, or inside that gap, is dropped.
- R5: At most RATE_MAX pulses are produced per window of RATE_WINDOW cycles. Windows are counted back to back from the release of reset. Further qualifying runs inside a full window are dropped.
- R6: trigOut is never high while allowIn is low. A run that qualifies while allowIn is low is dropped.
- R7: When allowIn falls during a pulse, trigOut goes low in the same cycle, and the pulse does not resume when allowIn returns.
- R8: When a synchronised high run reaches STUCK_TIMEOUT cycles, faultOut goes high and no pulse results from that run. faultOut clears after the synchronised input returns low.
- R9: reasonCode is a registered code with these values: 0 ready, 1 in reset, 2 permission low, 3 stuck input, 4 rate window full. When several conditions hold, stuck wins over permission low, and permission low wins over rate window full.
- R10: While reset is held, trigOut and faultOut are 0, reasonCode is 1 and rejectCount is 0, whatever the inputs do.
- R11: rejectCount increases by one for every synchronised high run that ends without producing a pulse, and it holds at its maximum value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigRaw | input | 1 | Raw trigger event line from the isolator, asynchronous |
| allowIn | input | 1 | Permission level; high permits output pulses |
| trigOut | output | 1 | Conditioned trigger pulse |
| faultOut | output | 1 | Stuck or open input fault |
| reasonCode | output | 3 | Current inhibit reason (R9 encoding) |
| rejectCount | output | REJ_W | Saturating count of dropped events |

## Verification
The condition hardest to reach from the ports is the rate ceiling. A run can only be dropped for rate, rather than for gap, when several qualifying runs land inside one window yet each one arrives after the previous pulse and its gap have fully ended. The bench therefore applies reset to align the window boundary, then spaces four minimum-width runs just beyond the pulse-plus-gap time. This shows the fourth one dropped with reason 4, and a later run accepted once the window has rolled over. The same timing care lets the stuck case be reached: a high level is held past the timeout, well clear of any earlier pulse, and then released.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  typedef enum logic [2:0] {
    RSN_READY    = 3'd0,
    RSN_RESET    = 3'd1,
    RSN_NO_ALLOW = 3'd2,
    RSN_STUCK    = 3'd3,
    RSN_RATE     = 3'd4
  } reason_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadPulse;
    logic clearPulse;
    logic countReject;
  } tpc_strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic runEnded;
    logic runQualified;
    logic pulseOn;
    logic gapOpen;
    logic rateFull;
    logic stuckHit;
  } tpc_status_t;

endpackage

// File: rtl/tpc_datapath.sv
module tpc_datapath
  import tpc_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int MIN_WIDTH     = 4,
  parameter int OUT_WIDTH     = 8,
  parameter int MIN_GAP       = 6,
  parameter int RATE_MAX      = 3,
  parameter int RATE_WINDOW   = 200,
  parameter int STUCK_TIMEOUT = 50,
  parameter int REJ_W         = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigRaw,
  input  logic              allowIn,
  input  tpc_strobe_t       strobe,
  output tpc_status_t       status,
  output logic              trigOut,
  output logic [REJ_W-1:0]  rejectCount
);

  localparam int HI_W   = $clog2(STUCK_TIMEOUT + 1);
  localparam int OUT_CW = $clog2(OUT_WIDTH + 1);
  localparam int GAP_W  = $clog2(MIN_GAP + 1);
  localparam int WIN_W  = $clog2(RATE_WINDOW + 1);
  localparam int RATE_W = $clog2(RATE_MAX + 1);

  localparam logic [HI_W-1:0]   STUCK_C   = HI_W'(STUCK_TIMEOUT);
  localparam logic [HI_W-1:0]   MINW_C    = HI_W'(MIN_WIDTH);
  localparam logic [OUT_CW-1:0] PULSE_LD  = OUT_CW'(OUT_WIDTH - 1);
  localparam logic [GAP_W-1:0]  GAP_LD    = GAP_W'(MIN_GAP - 1);
  localparam logic [WIN_W-1:0]  WIN_LAST  = WIN_W'(RATE_WINDOW - 1);
  localparam logic [RATE_W-1:0] RATE_CAP  = RATE_W'(RATE_MAX);

  // ---------------- input synchronizer ----------------
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncBit;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= trigRaw;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncChain <= '0;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], trigRaw};
      end
    end
  endgenerate

  assign syncBit = syncChain[SYNC_STAGES-1];

  // ---------------- high-run width measurement ----------------
  logic [HI_W-1:0] hiCnt;

  always_ff @(posedge clk) begin
    if (!rstN)               hiCnt <= '0;
    else if (!syncBit)       hiCnt <= '0;
    else if (hiCnt != STUCK_C) hiCnt <= hiCnt + 1'b1;
  end

  logic runEnded;
  assign runEnded = !syncBit && (hiCnt != '0);

  // ---------------- output pulse stretcher and gap timer ----------------
  logic              pulseOn;
  logic [OUT_CW-1:0] pulseCnt;
  logic [GAP_W-1:0]  gapCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseOn  <= 1'b0;
      pulseCnt <= '0;
      gapCnt   <= '0;
    end else begin
      if (gapCnt != '0) gapCnt <= gapCnt - 1'b1;
      if (strobe.clearPulse) begin
        pulseOn  <= 1'b0;
        pulseCnt <= '0;
        gapCnt   <= GAP_LD;
      end else if (strobe.loadPulse) begin
        pulseOn  <= 1'b1;
        pulseCnt <= PULSE_LD;
      end else if (pulseOn) begin
        if (pulseCnt == '0) begin
          pulseOn <= 1'b0;
          gapCnt  <= GAP_LD;
        end else begin
          pulseCnt <= pulseCnt - 1'b1;
        end
      end
    end
  end

  // ---------------- rate window ----------------
  logic [WIN_W-1:0]  winCnt;
  logic [RATE_W-1:0] rateCnt;
  logic              winWrap;

  assign winWrap = (winCnt == WIN_LAST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winCnt  <= '0;
      rateCnt <= '0;
    end else begin
      winCnt <= winWrap ? '0 : winCnt + 1'b1;
      if (winWrap)               rateCnt <= strobe.loadPulse ? RATE_W'(1) : '0;
      else if (strobe.loadPulse) rateCnt <= rateCnt + 1'b1;
    end
  end

  // ---------------- reject counter ----------------
  always_ff @(posedge clk) begin
    if (!rstN)
      rejectCount <= '0;
    else if (strobe.countReject && (rejectCount != {REJ_W{1'b1}}))
      rejectCount <= rejectCount + 1'b1;
  end

  // ---------------- status and output ----------------
  assign status.runEnded     = runEnded;
  assign status.runQualified = runEnded && (hiCnt >= MINW_C) && (hiCnt != STUCK_C);
  assign status.pulseOn      = pulseOn;
  assign status.gapOpen      = (gapCnt == '0);
  assign status.rateFull     = (rateCnt == RATE_CAP);
  assign status.stuckHit     = (hiCnt == STUCK_C);

  assign trigOut = pulseOn & allowIn;

  // ---------------- assertions ----------------
  AST_SHORT_RUN_NO_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseOn) |-> ($past(hiCnt) >= MINW_C)); // R1

  AST_STUCK_RUN_NO_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseOn) |-> ($past(hiCnt) != STUCK_C)); // R8

  AST_GAP_BEFORE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseOn) |-> ($past(gapCnt) == '0)); // R4

  AST_RATE_CEILING: assert property (@(posedge clk) disable iff (!rstN)
    rateCnt <= RATE_CAP); // R5

  AST_TRUNC_AT_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    (pulseOn && !allowIn) |=> !pulseOn); // R7

  AST_REJECT_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    rejectCount >= $past(rejectCount)); // R11

endmodule

// File: rtl/tpc_control.sv
module tpc_control
  import tpc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        allowIn,
  input  tpc_status_t status,
  output tpc_strobe_t strobe,
  output logic        faultOut,
  output logic [2:0]  reasonCode
);

  reason_e reasonReg;
  reason_e reasonNext;
  logic    faultReg;

  // accept decision: qualified run, permission, idle, gap elapsed, window not full
  always_comb begin
    strobe.loadPulse   = status.runQualified && allowIn && !status.pulseOn &&
                         status.gapOpen && !status.rateFull;
    strobe.clearPulse  = status.pulseOn && !allowIn;
    strobe.countReject = status.runEnded && !strobe.loadPulse;
  end

  always_comb begin
    if (status.stuckHit)      reasonNext = RSN_STUCK;
    else if (!allowIn)        reasonNext = RSN_NO_ALLOW;
    else if (status.rateFull) reasonNext = RSN_RATE;
    else                      reasonNext = RSN_READY;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reasonReg <= RSN_RESET;
      faultReg  <= 1'b0;
    end else begin
      reasonReg <= reasonNext;
      faultReg  <= status.stuckHit;
    end
  end

  assign reasonCode = reasonReg;
  assign faultOut   = faultReg;

  AST_FAULT_MEANS_STUCK_REASON: assert property (@(posedge clk) disable iff (!rstN)
    faultOut |-> (reasonCode == RSN_STUCK)); // R9

  AST_NO_REJECT_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadPulse |=> status.pulseOn); // R2

endmodule

// File: rtl/trig_pulse_conditioner.sv
module trig_pulse_conditioner
  import tpc_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int MIN_WIDTH     = 4,
  parameter int OUT_WIDTH     = 8,
  parameter int MIN_GAP       = 6,
  parameter int RATE_MAX      = 3,
  parameter int RATE_WINDOW   = 200,
  parameter int STUCK_TIMEOUT = 50,
  parameter int REJ_W         = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigRaw,
  input  logic             allowIn,
  output logic             trigOut,
  output logic             faultOut,
  output logic [2:0]       reasonCode,
  output logic [REJ_W-1:0] rejectCount
);

  tpc_strobe_t strobe;
  tpc_status_t status;

  tpc_datapath #(
    .SYNC_STAGES  (SYNC_STAGES),
    .MIN_WIDTH    (MIN_WIDTH),
    .OUT_WIDTH    (OUT_WIDTH),
    .MIN_GAP      (MIN_GAP),
    .RATE_MAX     (RATE_MAX),
    .RATE_WINDOW  (RATE_WINDOW),
    .STUCK_TIMEOUT(STUCK_TIMEOUT),
    .REJ_W        (REJ_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .trigRaw    (trigRaw),
    .allowIn    (allowIn),
    .strobe     (strobe),
    .status     (status),
    .trigOut    (trigOut),
    .rejectCount(rejectCount)
  );

  tpc_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .allowIn   (allowIn),
    .status    (status),
    .strobe    (strobe),
    .faultOut  (faultOut),
    .reasonCode(reasonCode)
  );

endmodule

// File: tb/trig_pulse_conditioner_bench.sv
`timescale 1ns/1ps
module trig_pulse_conditioner_bench;

  localparam int MIN_WIDTH = 4;
  localparam int OUT_WIDTH = 8;
  localparam int MIN_GAP   = 6;
  localparam int STUCK     = 50;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       trigRaw = 1'b0;
  logic       allowIn = 1'b1;
  logic       trigOut;
  logic       faultOut;
  logic [2:0] reasonCode;
  logic [7:0] rejectCount;

  always #2.5 clk = ~clk;

  trig_pulse_conditioner u_trig_pulse_conditioner (
    .clk(clk), .rstN(rstN), .trigRaw(trigRaw), .allowIn(allowIn),
    .trigOut(trigOut), .faultOut(faultOut), .reasonCode(reasonCode),
    .rejectCount(rejectCount)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // vector table: raw width, permission, expected pulse (1/0)
  localparam int NV = 9;
  localparam int VEC_W     [NV] = '{2, 3, 4, 10, 4, 49, 1, 50, 5};
  localparam int VEC_ALLOW [NV] = '{1, 1, 1, 1,  0, 1,  1, 1,  1};
  localparam int VEC_PULSE [NV] = '{0, 0, 1, 1,  0, 1,  0, 0,  1};

  // output monitor
  int pulseCount = 0;
  int lastWidth = 0;
  int highRun = 0;
  int lowRun = 0;
  int minGapSeen = 1000;
  int allowViol = 0;
  bit seenPulse = 0;

  always @(negedge clk) begin
    if (trigOut && !allowIn) allowViol++;
    if (trigOut) begin
      if (highRun == 0) begin
        pulseCount++;
        if (seenPulse && lowRun < minGapSeen) minGapSeen = lowRun;
      end
      highRun++;
      lowRun = 0;
    end else begin
      if (highRun != 0) begin
        lastWidth = highRun;
        seenPulse = 1;
      end
      highRun = 0;
      lowRun++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendPulse(input int w);
    @(negedge clk) trigRaw = 1'b1;
    repeat (w) @(negedge clk);
    trigRaw = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    trigRaw = 1'b1;
    allowIn = 1'b1;
    repeat (4) @(negedge clk);
    check(trigOut == 1'b0, "R10 trigOut in reset", trigOut, 0);
    check(faultOut == 1'b0, "R10 faultOut in reset", faultOut, 0);
    check(reasonCode == 3'd1, "R10 reason in reset", reasonCode, 1);
    check(rejectCount == 8'd0, "R10 count in reset", rejectCount, 0);
    trigRaw = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    doReset();
    check(reasonCode == 3'd0, "R9 ready after reset", reasonCode, 0);

    // ---- table walk: R1 R2 R3 R6 R8 R11 ----
    for (int i = 0; i < NV; i++) begin
      int p0, r0;
      p0 = pulseCount;
      r0 = rejectCount;
      allowIn = VEC_ALLOW[i][0];
      sendPulse(VEC_W[i]);
      repeat (80) @(negedge clk);
      allowIn = 1'b1;
      check(pulseCount - p0 == VEC_PULSE[i], $sformatf("R1/R2 vec%0d pulses", i),
            pulseCount - p0, VEC_PULSE[i]);
      check(rejectCount - r0 == 1 - VEC_PULSE[i], $sformatf("R11 vec%0d rejects", i),
            rejectCount - r0, 1 - VEC_PULSE[i]);
      if (VEC_PULSE[i] == 1)
        check(lastWidth == OUT_WIDTH, $sformatf("R3 vec%0d width", i), lastWidth, OUT_WIDTH);
    end

    // ---- R2 exact latency from falling raw edge ----
    begin
      int k;
      k = 0;
      sendPulse(MIN_WIDTH);
      while (!trigOut && k < 20) begin
        @(negedge clk);
        k++;
      end
      check(k == 3, "R2 latency", k, 3);
      repeat (80) @(negedge clk);
    end

    // ---- R4 second event while the first pulse is active ----
    begin
      int p0, r0;
      doReset();
      p0 = pulseCount;
      r0 = rejectCount;
      sendPulse(4);
      repeat (2) @(negedge clk);
      sendPulse(4);
      repeat (40) @(negedge clk);
      check(pulseCount - p0 == 1, "R4 busy event dropped", pulseCount - p0, 1);
      check(rejectCount - r0 == 1, "R4 busy event counted", rejectCount - r0, 1);
    end

    // ---- R5 rate window ----
    begin
      int p0, r0;
      doReset();
      p0 = pulseCount;
      r0 = rejectCount;
      for (int j = 0; j < 4; j++) begin
        sendPulse(4);
        repeat (16) @(negedge clk);
      end
      check(pulseCount - p0 == 3, "R5 pulses in window", pulseCount - p0, 3);
      check(rejectCount - r0 == 1, "R5 excess counted", rejectCount - r0, 1);
      check(reasonCode == 3'd4, "R9 rate full reason", reasonCode, 4);
      allowIn = 1'b0;
      repeat (2) @(negedge clk);
      check(reasonCode == 3'd2, "R9 permission over rate", reasonCode, 2);
      allowIn = 1'b1;
      repeat (140) @(negedge clk);
      check(reasonCode == 3'd0, "R5 window rolled over", reasonCode, 0);
      sendPulse(4);
      repeat (20) @(negedge clk);
      check(pulseCount - p0 == 4, "R5 accept in new window", pulseCount - p0, 4);
    end

    // ---- R7 truncation ----
    begin
      bit stayedLow;
      doReset();
      sendPulse(4);
      while (!trigOut) @(negedge clk);
      repeat (2) @(negedge clk);
      allowIn = 1'b0;
      #1;
      check(trigOut == 1'b0, "R7 cut same cycle", trigOut, 0);
      repeat (3) @(negedge clk);
      check(reasonCode == 3'd2, "R9 permission low reason", reasonCode, 2);
      allowIn = 1'b1;
      stayedLow = 1;
      repeat (10) begin
        @(negedge clk);
        if (trigOut) stayedLow = 0;
      end
      check(stayedLow, "R7 no resume", stayedLow, 1);
    end

    // ---- R8 stuck input ----
    begin
      int p0, r0;
      repeat (40) @(negedge clk);
      p0 = pulseCount;
      r0 = rejectCount;
      trigRaw = 1'b1;
      repeat (60) @(negedge clk);
      check(faultOut == 1'b1, "R8 fault set", faultOut, 1);
      check(reasonCode == 3'd3, "R9 stuck reason", reasonCode, 3);
      allowIn = 1'b0;
      repeat (2) @(negedge clk);
      check(reasonCode == 3'd3, "R9 stuck over permission", reasonCode, 3);
      allowIn = 1'b1;
      trigRaw = 1'b0;
      repeat (20) @(negedge clk);
      check(faultOut == 1'b0, "R8 fault cleared", faultOut, 0);
      check(pulseCount == p0, "R8 no pulse", pulseCount - p0, 0);
      check(rejectCount - r0 == 1, "R11 stuck run counted", rejectCount - r0, 1);
    end

    // ---- R11 saturation ----
    doReset();
    for (int j = 0; j < 260; j++) begin
      sendPulse(2);
      repeat (3) @(negedge clk);
    end
    repeat (5) @(negedge clk);
    check(rejectCount == 8'd255, "R11 saturation", rejectCount, 255);

    check(minGapSeen >= MIN_GAP, "R4 min gap", minGapSeen, MIN_GAP);
    check(allowViol == 0, "R6 pulse without permission", allowViol, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule